// File: doc/BRIEF.md
# Configuration Port with Unlock Key

This block models the configuration space of a multi-function I/O controller that software reaches through a pair of byte ports. One port takes a register index and the other carries data. After reset the space is locked. In that state every byte written to the index port is compared against a four-byte unlock key, and the data port does nothing. The last byte of the key depends on which base address the port pair sits at.

Once the key has been matched, software writes a register index to the index port and then reads or writes that register through the data port. The space holds:

- a two-byte chip identifier;
- a global register of flash decode enables;
- a logical-device select register;
- a register bank that exists only for the flash logical device. This bank holds the 16-bit base address of a serial flash command port.

A fixed write to the exit register locks the space again. The programmed flash base is driven on an output. That output changes only as a whole 16-bit value, so it never shows a half-written base.

Top module: `cfgport_unlock`

## Requirements
- R1: While locked, four index-port writes (busSel=0) of 0x87, 0x01, 0x55 and then the final key byte set cfgMode at the clock edge that takes the fourth byte. Writes of only the first three bytes leave cfgMode low.
- R2: The final key byte is 0xAA when PORT_BASE is 0x4E, and 0x55 for any other base (0x2E by default).
- R3: A byte that does not match the expected key byte restarts the match from the beginning. If that byte is 0x87, it counts as the first key byte of a new attempt.
- R4: While locked, reads of either port return 0xFF. Data-port writes change no register, and index-port writes do not change the selected index.
- R5: While unlocked, an index-port write selects a register, an index-port read returns the selected index, and data-port accesses reach the selected register. Unmapped registers read 0x00.
- R6: Registers 0x20 and 0x21 read 0x87 and 0x16, and writes to them have no effect.
- R7: Register 0x07 is the logical-device select register. It reads back the last byte written to it and resets to 0x00.
- R8: With device 7 selected, registers 0x64 and 0x65 read back the last high and low base bytes written. With any other device selected they read 0x00 and writes to them are ignored.
- R9: flashBase takes {high, low} only when both base bytes have been written since its last update, in either order. Otherwise it holds its value.
- R10: Register 0x24 stores bits 1 to 5 of a written byte (three segment enables, flash write enable, flash pin select). Bits 0, 6 and 7 read 0.
- R11: Writing 0x02 to register 0x02 clears cfgMode. Any other value written there is ignored.
- R12: After reset the block is locked, flashBase is 0x0000, and busRdata is 0x00 while busRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Byte write strobe |
| busRd | input | 1 | Byte read strobe |
| busSel | input | 1 | 0 selects the index port, 1 selects the data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational while busRd is high |
| cfgMode | output | 1 | High while the configuration space is unlocked |
| flashBase | output | 16 | Programmed flash command port base |

## Verification
The assertions assume that each access lasts exactly one clock, that busWr and busRd are never high together, and that inputs change only away from the rising edge. The stimulus keeps to these rules because every access goes through a task that raises the strobe at a falling edge and drops it at the next falling edge. Both port-base variants share one bus. Every index write therefore reaches the locked instance's key matcher as well, and the order of writes is chosen so that neither instance is unlocked by accident.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DATA_W  = 8;
  localparam int KEY_LEN = 4;

  typedef struct packed {
    logic              unlocked;
    logic              dataWr;
    logic [DATA_W-1:0] index;
  } cfgStrobe_t;

  localparam logic [DATA_W-1:0] REG_EXIT    = 8'h02;
  localparam logic [DATA_W-1:0] EXIT_VALUE  = 8'h02;
  localparam logic [DATA_W-1:0] REG_LDN     = 8'h07;
  localparam logic [DATA_W-1:0] REG_ID_HI   = 8'h20;
  localparam logic [DATA_W-1:0] REG_ID_LO   = 8'h21;
  localparam logic [DATA_W-1:0] REG_DECODE  = 8'h24;
  localparam logic [DATA_W-1:0] REG_BASE_HI = 8'h64;
  localparam logic [DATA_W-1:0] REG_BASE_LO = 8'h65;
  localparam logic [DATA_W-1:0] DECODE_MASK = 8'h3E;
  localparam logic [DATA_W-1:0] LOCKED_READ = 8'hFF;

  function automatic logic [DATA_W-1:0] keyByte(input int pos, input logic [15:0] portBase);
    case (pos)
      0:       keyByte = 8'h87;
      1:       keyByte = 8'h01;
      2:       keyByte = 8'h55;
      default: keyByte = (portBase == 16'h004E) ? 8'hAA : 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busWdata,
  output cfgStrobe_t        strobe
);
  localparam int CNT_W = $clog2(KEY_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(KEY_LEN - 1);
  localparam logic [DATA_W-1:0] FIRST_KEY = keyByte(0, PORT_BASE);
  localparam logic [DATA_W-1:0] FINAL_KEY = keyByte(KEY_LEN - 1, PORT_BASE);

  logic [CNT_W-1:0]  keyCnt;
  logic              unlocked;
  logic [DATA_W-1:0] indexReg;
  logic [DATA_W-1:0] expectKey;
  logic              idxWr;
  logic              dataWr;

  assign idxWr  = busWr && !busSel;
  assign dataWr = busWr && busSel && unlocked;

  always_comb begin
    expectKey = FIRST_KEY;
    for (int i = 0; i < KEY_LEN; i++) begin
      if (keyCnt == CNT_W'(i)) expectKey = keyByte(i, PORT_BASE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCnt   <= '0;
      unlocked <= 1'b0;
      indexReg <= '0;
    end else if (!unlocked) begin
      if (idxWr) begin
        if (busWdata == expectKey) begin
          if (keyCnt == LAST_POS) begin
            unlocked <= 1'b1;
            keyCnt   <= '0;
          end else begin
            keyCnt <= keyCnt + 1'b1;
          end
        end else begin
          keyCnt <= (busWdata == FIRST_KEY) ? CNT_W'(1) : '0;
        end
      end
    end else if (idxWr) begin
      indexReg <= busWdata;
    end else if (dataWr && indexReg == REG_EXIT && busWdata == EXIT_VALUE) begin
      unlocked <= 1'b0;
    end
  end

  always_comb begin
    strobe.unlocked = unlocked;
    strobe.dataWr   = dataWr;
    strobe.index    = indexReg;
  end

  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busWr && !busSel && busWdata == FINAL_KEY)); // R1
  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && busWr && busSel && indexReg == REG_EXIT && busWdata == EXIT_VALUE) |=> !unlocked); // R11
  AST_LOCKED_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(indexReg)); // R4
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_HI     = 8'h87,
  parameter logic [DATA_W-1:0] ID_LO     = 8'h16,
  parameter logic [DATA_W-1:0] FLASH_DEV = 8'h07
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic                busRd,
  input  logic                busSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [2*DATA_W-1:0] flashBase
);
  logic [DATA_W-1:0] ldnSel;
  logic [DATA_W-1:0] decodeEn;
  logic [DATA_W-1:0] baseHi;
  logic [DATA_W-1:0] baseLo;
  logic              hiSeen;
  logic              loSeen;
  logic              devFlash;
  logic              wrHi;
  logic              wrLo;

  assign devFlash = (ldnSel == FLASH_DEV);
  assign wrHi = strobe.dataWr && devFlash && strobe.index == REG_BASE_HI;
  assign wrLo = strobe.dataWr && devFlash && strobe.index == REG_BASE_LO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnSel    <= '0;
      decodeEn  <= '0;
      baseHi    <= '0;
      baseLo    <= '0;
      hiSeen    <= 1'b0;
      loSeen    <= 1'b0;
      flashBase <= '0;
    end else begin
      if (strobe.dataWr && strobe.index == REG_LDN) ldnSel <= busWdata;
      if (strobe.dataWr && strobe.index == REG_DECODE) decodeEn <= busWdata & DECODE_MASK;
      if (wrHi) begin
        baseHi <= busWdata;
        if (loSeen) begin
          flashBase <= {busWdata, baseLo};
          loSeen    <= 1'b0;
          hiSeen    <= 1'b0;
        end else begin
          hiSeen <= 1'b1;
        end
      end
      if (wrLo) begin
        baseLo <= busWdata;
        if (hiSeen) begin
          flashBase <= {baseHi, busWdata};
          hiSeen    <= 1'b0;
          loSeen    <= 1'b0;
        end else begin
          loSeen <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (!strobe.unlocked) begin
        busRdata = LOCKED_READ;
      end else if (!busSel) begin
        busRdata = strobe.index;
      end else begin
        case (strobe.index)
          REG_ID_HI:   busRdata = ID_HI;
          REG_ID_LO:   busRdata = ID_LO;
          REG_LDN:     busRdata = ldnSel;
          REG_DECODE:  busRdata = decodeEn;
          REG_BASE_HI: busRdata = devFlash ? baseHi : '0;
          REG_BASE_LO: busRdata = devFlash ? baseLo : '0;
          default:     busRdata = '0;
        endcase
      end
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataWr && devFlash && (strobe.index == REG_BASE_HI || strobe.index == REG_BASE_LO))
      |=> $stable(flashBase)); // R9
  AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataWr && strobe.index == REG_LDN) |=> $stable(ldnSel)); // R7
endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter logic [15:0] PORT_BASE = 16'h002E,
  parameter logic [7:0]  ID_HI     = 8'h87,
  parameter logic [7:0]  ID_LO     = 8'h16,
  parameter logic [7:0]  FLASH_DEV = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        busSel,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        cfgMode,
  output logic [15:0] flashBase
);
  cfgStrobe_t strobe;

  cfgport_ctrl #(.PORT_BASE(PORT_BASE)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWdata(busWdata), .strobe(strobe)
  );

  cfgport_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO), .FLASH_DEV(FLASH_DEV)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .flashBase(flashBase)
  );

  assign cfgMode = strobe.unlocked;
endmodule

// File: tb/cfgport_unlock_tb_top.sv
module cfgport_unlock_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        busSel = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  rdA, rdB;
  logic        cfgA, cfgB;
  logic [15:0] baseA, baseB;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfgport_unlock #(.PORT_BASE(16'h002E)) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(rdA), .cfgMode(cfgA), .flashBase(baseA)
  );

  cfgport_unlock #(.PORT_BASE(16'h004E)) dut4e_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(rdB), .cfgMode(cfgB), .flashBase(baseB)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic useB, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busRd = 1'b1; busSel = sel;
    #1;
    chk(tag, {8'h00, useB ? rdB : rdA}, {8'h00, exp});
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] idx, input logic useB, input logic [7:0] exp, input string tag);
    wr(1'b0, idx);
    rd(1'b1, useB, exp, tag);
  endtask

  task automatic regWr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic t_reset;
    chk("R12 cfgMode after reset", {15'd0, cfgA}, 16'd0);
    chk("R12 flashBase after reset", baseA, 16'h0000);
    chk("R12 rdata idle", {8'h00, rdA}, 16'h0000);
  endtask

  task automatic t_locked;
    rd(1'b1, 1'b0, 8'hFF, "R4 locked data read");
    rd(1'b0, 1'b0, 8'hFF, "R4 locked index read");
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h05);
  endtask

  task automatic t_unlockA;
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55);
    chk("R1 three key bytes stay locked", {15'd0, cfgA}, 16'd0);
    wr(1'b0, 8'h55);
    chk("R1 key unlocks 0x2E port", {15'd0, cfgA}, 16'd1);
    chk("R2 0x55 final byte does not unlock 0x4E port", {15'd0, cfgB}, 16'd0);
  endtask

  task automatic t_ids;
    regRd(8'h20, 1'b0, 8'h87, "R6 id high");
    regRd(8'h21, 1'b0, 8'h16, "R6 id low");
    regWr(8'h20, 8'h00);
    regRd(8'h20, 1'b0, 8'h87, "R6 id high write ignored");
    regRd(8'h07, 1'b0, 8'h00, "R4 locked data write ignored");
    rd(1'b0, 1'b0, 8'h07, "R5 index port readback");
    regRd(8'h30, 1'b0, 8'h00, "R5 unmapped reads zero");
  endtask

  task automatic t_flashBase;
    regWr(8'h07, 8'h03);
    regRd(8'h07, 1'b0, 8'h03, "R7 device select readback");
    regWr(8'h64, 8'h12);
    regRd(8'h64, 1'b0, 8'h00, "R8 base reg hidden for other device");
    regWr(8'h07, 8'h07);
    regRd(8'h64, 1'b0, 8'h00, "R8 write under other device ignored");
    regWr(8'h64, 8'h0A);
    chk("R9 high byte alone holds base", baseA, 16'h0000);
    regRd(8'h64, 1'b0, 8'h0A, "R8 base high readback");
    regWr(8'h65, 8'h90);
    chk("R9 base after high then low", baseA, 16'h0A90);
    regWr(8'h65, 8'h33);
    chk("R9 low byte alone holds base", baseA, 16'h0A90);
    regRd(8'h65, 1'b0, 8'h33, "R8 base low readback");
    regWr(8'h64, 8'h0B);
    chk("R9 base after low then high", baseA, 16'h0B33);
  endtask

  task automatic t_decode;
    regWr(8'h24, 8'hFF);
    regRd(8'h24, 1'b0, 8'h3E, "R10 decode mask");
  endtask

  task automatic t_exit;
    regWr(8'h02, 8'h01);
    chk("R11 wrong exit value ignored", {15'd0, cfgA}, 16'd1);
    regWr(8'h02, 8'h02);
    chk("R11 exit locks", {15'd0, cfgA}, 16'd0);
    rd(1'b1, 1'b0, 8'hFF, "R4 read after exit");
    chk("R9 base kept after exit", baseA, 16'h0B33);
  endtask

  task automatic t_restart;
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h33); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    chk("R3 wrong byte restarts match", {15'd0, cfgA}, 16'd0);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h87);
    wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    chk("R3 mismatching 0x87 starts new attempt", {15'd0, cfgA}, 16'd1);
    regWr(8'h02, 8'h02);
  endtask

  task automatic t_unlockB;
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'hAA);
    chk("R2 0xAA unlocks 0x4E port", {15'd0, cfgB}, 16'd1);
    chk("R2 0xAA does not unlock 0x2E port", {15'd0, cfgA}, 16'd0);
    regRd(8'h21, 1'b1, 8'h16, "R6 id low on 0x4E port");
    rd(1'b1, 1'b0, 8'hFF, "R4 0x2E port still locked");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlockA();
    t_ids();
    t_flashBase();
    t_decode();
    t_exit();
    t_restart();
    t_unlockB();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule